// File: doc/BRIEF.md
# Programmable-Priority Local Interrupt Selector

This block chooses a single winner among up to 64 local interrupt sources that are already pending and enabled for one privilege level. Each source owns an 8-bit priority register, loaded through a one-entry-per-cycle write port. A smaller effective priority wins. A stored priority of zero does not mean "highest"; the block replaces it with a substitute value. The substitute depends on where the source stands in a fixed interleaved default order, compared with the level's own external interrupt.

The same default order breaks every tie, so the result is always unique. When the priority feature is switched off, the block reduces to a plain "lowest-numbered pending source" encoder. The winner's number and its effective priority are registered, so a consumer such as a trap-entry or top-interrupt read path sees a stable result one cycle after the pending vector changes.

Top module: `prio_irq_sel`

## Requirements
- R1: While `rst_ni` is low, every stored priority is cleared to zero and `valid_o`, `id_o` and `prio_o` are all zero.
- R2: The outputs are registered. At each clock edge they reflect `irq_i` and `prio_en_i` sampled at that edge. With no bit of `irq_i` set, `valid_o`, `id_o` and `prio_o` are all zero.
- R3: A source whose stored priority is nonzero uses that value as its effective priority, and the smallest effective priority among pending sources wins.
- R4: The level's external source (index `EXT_IRQ`, default 11) with a stored priority of zero takes the effective priority `EXT_DEF_PRIO` (default 128, which must be nonzero).
- R5: Any other source with a stored priority of zero takes effective priority 1 if it ranks above `EXT_IRQ` in the default order, and 255 if it ranks below.
- R6: Default order, highest first: 63,62,31,30,61,60,59,58,29,28,57,56,55,54,27,26,53,52,51,50,25,24,49,48, then 11,3,7,9,1,5,12,10,2,6, then 47,46,23,22,45,44,43,42,21,20,41,40,39,38,19,18,37,36,35,34,17,16,33,32, then the remaining sources 15,14,13,8,4,0.
- R7: Among pending sources with equal effective priority, the one ranking higher in the default order wins (for example 11 beats 3, and 3 beats 7).
- R8: With `prio_en_i` low, the lowest-numbered pending source wins, and `prio_o` still reports that source's effective priority.
- R9: A write with `wr_en_i` high and `wr_idx_i` below `NUM_SRC` stores `wr_prio_i` at that edge. The winner computed at the next edge already uses the new value.
- R10: A write whose `wr_idx_i` is `NUM_SRC` or more changes no stored priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | NUM_SRC | Pending-and-enabled sources, bit n is source n |
| prio_en_i | input | 1 | 1: programmable priorities; 0: lowest number wins |
| wr_en_i | input | 1 | Priority write strobe |
| wr_idx_i | input | IDX_W+1 | Source index to write |
| wr_prio_i | input | PRIO_W | Priority value to store |
| valid_o | output | 1 | A source is selected |
| id_o | output | IDX_W | Selected source number |
| prio_o | output | PRIO_W | Effective priority of the selected source |

## Verification
The assertions check on every cycle that the selection flag follows the registered pending vector and that the reported number always points at a pending bit. They also check that idle outputs are zero, that the effective priority is never zero, and that in disabled mode no lower-numbered source was pending. Only the bench's scenarios can show the arithmetic of selection: the zero-priority substitutes on each side of the external source, tie-breaking by default rank, the one-cycle visibility of a write and the rejection of out-of-range writes. The bench checks these against a reference model built from an explicit order list.

// File: rtl/prio_sel_pkg.sv
package prio_sel_pkg;

  localparam int unsigned SRC_MAX = 64;

  // Position in the default order, 0 = highest.
  function automatic int def_rank(input int src);
    int d, k, j;
    if (src >= 48) begin
      d = 63 - src; k = d / 4; j = d % 4;
      return 6 * k + ((j < 2) ? j : j + 2);
    end else if (src >= 32) begin
      d = 47 - src; k = d / 4; j = d % 4;
      return 34 + 6 * k + ((j < 2) ? j : j + 2);
    end else if (src >= 24) begin
      d = 31 - src; k = d / 2; j = d % 2;
      return 6 * k + 2 + j;
    end else if (src >= 16) begin
      d = 23 - src; k = d / 2; j = d % 2;
      return 34 + 6 * k + 2 + j;
    end
    case (src)
      11: return 24;
      3:  return 25;
      7:  return 26;
      9:  return 27;
      1:  return 28;
      5:  return 29;
      12: return 30;
      10: return 31;
      2:  return 32;
      6:  return 33;
      15: return 58;
      14: return 59;
      13: return 60;
      8:  return 61;
      4:  return 62;
      default: return 63;
    endcase
  endfunction

endpackage

// File: rtl/prio_sel_regs.sv
module prio_sel_regs #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned PRIO_W  = 8,
  parameter int unsigned WIDX    = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WIDX-1:0]   wr_idx_i,
  input  logic [PRIO_W-1:0] wr_prio_i,
  output logic [PRIO_W-1:0] prio_o [NUM_SRC]
);

  // Full-width index compare: out-of-range indices match no entry.
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prio_o[i] <= '0;
      end else if (wr_en_i && (wr_idx_i == WIDX'(i))) begin
        prio_o[i] <= wr_prio_i;
      end
    end
  end

endmodule

// File: rtl/prio_sel_eff.sv
module prio_sel_eff #(
  parameter int unsigned NUM_SRC      = 64,
  parameter int unsigned PRIO_W       = 8,
  parameter int unsigned IDX_W        = 6,
  parameter int unsigned EXT_IRQ      = 11,
  parameter int unsigned EXT_DEF_PRIO = 128,
  localparam int unsigned KEY_W       = PRIO_W + IDX_W
) (
  input  logic              prio_en_i,
  input  logic [PRIO_W-1:0] prio_i [NUM_SRC],
  output logic [PRIO_W-1:0] eff_o  [NUM_SRC],
  output logic [KEY_W-1:0]  key_o  [NUM_SRC]
);

  localparam int EXT_RANK = prio_sel_pkg::def_rank(int'(EXT_IRQ));

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam int RANK = prio_sel_pkg::def_rank(i);
    localparam logic [PRIO_W-1:0] FILL =
      (i == int'(EXT_IRQ)) ? PRIO_W'(EXT_DEF_PRIO) :
      (RANK < EXT_RANK)    ? PRIO_W'(1) : {PRIO_W{1'b1}};

    always_comb begin
      eff_o[i] = (prio_i[i] != '0) ? prio_i[i] : FILL;
      // Rank in low bits makes keys unique and breaks ties.
      key_o[i] = prio_en_i ? {eff_o[i], IDX_W'(RANK)}
                           : {{PRIO_W{1'b0}}, IDX_W'(i)};
    end
  end

endmodule

// File: rtl/prio_sel_tree.sv
module prio_sel_tree #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned PRIO_W  = 8,
  parameter int unsigned IDX_W   = 6,
  localparam int unsigned KEY_W  = PRIO_W + IDX_W,
  localparam int unsigned LEAVES = 1 << IDX_W,
  localparam int unsigned NODES  = 2 * LEAVES - 1
) (
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [PRIO_W-1:0]  eff_i [NUM_SRC],
  input  logic [KEY_W-1:0]   key_i [NUM_SRC],
  output logic               valid_o,
  output logic [IDX_W-1:0]   id_o,
  output logic [PRIO_W-1:0]  prio_o
);

  typedef struct packed {
    logic              vld;
    logic [KEY_W-1:0]  key;
    logic [IDX_W-1:0]  id;
    logic [PRIO_W-1:0] prio;
  } node_t;

  node_t node [NODES];

  always_comb begin
    for (int n = 0; n < NODES; n++) node[n] = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      node[LEAVES-1+i].vld  = req_i[i];
      node[LEAVES-1+i].key  = key_i[i];
      node[LEAVES-1+i].id   = IDX_W'(i);
      node[LEAVES-1+i].prio = eff_i[i];
    end
    for (int n = LEAVES - 2; n >= 0; n--) begin
      if (node[2*n+1].vld && (!node[2*n+2].vld || node[2*n+1].key <= node[2*n+2].key))
        node[n] = node[2*n+1];
      else
        node[n] = node[2*n+2];
    end
  end

  assign valid_o = node[0].vld;
  assign id_o    = node[0].vld ? node[0].id   : '0;
  assign prio_o  = node[0].vld ? node[0].prio : '0;

endmodule

// File: rtl/prio_irq_sel.sv
module prio_irq_sel #(
  parameter int unsigned NUM_SRC      = 64,
  parameter int unsigned PRIO_W       = 8,
  parameter int unsigned EXT_IRQ      = 11,
  parameter int unsigned EXT_DEF_PRIO = 128,
  localparam int unsigned IDX_W       = $clog2(NUM_SRC),
  localparam int unsigned WIDX        = IDX_W + 1,
  localparam int unsigned KEY_W       = PRIO_W + IDX_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic               prio_en_i,
  input  logic               wr_en_i,
  input  logic [WIDX-1:0]    wr_idx_i,
  input  logic [PRIO_W-1:0]  wr_prio_i,
  output logic               valid_o,
  output logic [IDX_W-1:0]   id_o,
  output logic [PRIO_W-1:0]  prio_o
);

  logic [PRIO_W-1:0] stored [NUM_SRC];
  logic [PRIO_W-1:0] eff    [NUM_SRC];
  logic [KEY_W-1:0]  key    [NUM_SRC];
  logic              sel_vld;
  logic [IDX_W-1:0]  sel_id;
  logic [PRIO_W-1:0] sel_prio;

  prio_sel_regs #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .WIDX(WIDX)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_idx_i  (wr_idx_i),
    .wr_prio_i (wr_prio_i),
    .prio_o    (stored)
  );

  prio_sel_eff #(
    .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W),
    .EXT_IRQ(EXT_IRQ), .EXT_DEF_PRIO(EXT_DEF_PRIO)
  ) u_eff (
    .prio_en_i (prio_en_i),
    .prio_i    (stored),
    .eff_o     (eff),
    .key_o     (key)
  );

  prio_sel_tree #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_tree (
    .req_i   (irq_i),
    .eff_i   (eff),
    .key_i   (key),
    .valid_o (sel_vld),
    .id_o    (sel_id),
    .prio_o  (sel_prio)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      id_o    <= '0;
      prio_o  <= '0;
    end else begin
      valid_o <= sel_vld;
      id_o    <= sel_id;
      prio_o  <= sel_prio;
    end
  end

endmodule

// File: rtl/prio_irq_sel_chk.sv
module prio_irq_sel_chk #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned PRIO_W  = 8,
  parameter int unsigned IDX_W   = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] irq_i,
  input logic               prio_en_i,
  input logic               valid_o,
  input logic [IDX_W-1:0]   id_o,
  input logic [PRIO_W-1:0]  prio_o
);

  logic [NUM_SRC-1:0] irq_q;
  logic               en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= '0;
      en_q  <= 1'b0;
    end else begin
      irq_q <= irq_i;
      en_q  <= prio_en_i;
    end
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_idle: assert (!valid_o && id_o == '0 && prio_o == '0);
    end
  end

  a_r2_valid_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == (|irq_q));

  a_r2_id_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> irq_q[id_o]);

  a_r2_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (id_o == '0 && prio_o == '0));

  a_r3_prio_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> prio_o != '0);

  a_r8_lowest_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !en_q) |-> ((irq_q & ((NUM_SRC'(1) << id_o) - NUM_SRC'(1))) == '0));

endmodule

bind prio_irq_sel prio_irq_sel_chk #(
  .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .irq_i     (irq_i),
  .prio_en_i (prio_en_i),
  .valid_o   (valid_o),
  .id_o      (id_o),
  .prio_o    (prio_o)
);

// File: tb/tb_prio_irq_sel.sv
module tb_prio_irq_sel;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] irq_i = '0;
  logic        prio_en_i = 1'b1;
  logic        wr_en_i = 1'b0;
  logic [6:0]  wr_idx_i = '0;
  logic [7:0]  wr_prio_i = '0;
  logic        valid_o;
  logic [5:0]  id_o;
  logic [7:0]  prio_o;

  prio_irq_sel dut (.*);

  always #5 clk_i = ~clk_i;

  typedef struct {
    bit    v;
    int    id;
    int    pr;
    string tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;
  int   mp  [64];
  int   rnk [64];
  int   ord [64] = '{63,62,31,30,61,60,59,58,29,28,57,56,55,54,27,26,53,52,51,50,25,24,49,48,
                     11,3,7,9,1,5,12,10,2,6,
                     47,46,23,22,45,44,43,42,21,20,41,40,39,38,19,18,37,36,35,34,17,16,33,32,
                     15,14,13,8,4,0};

  function automatic int eff(int s);
    if (mp[s] != 0) return mp[s];
    if (s == 11) return 128;
    return (rnk[s] < rnk[11]) ? 1 : 255;
  endfunction

  function automatic exp_t model(logic [63:0] irq, bit en, string tag);
    exp_t e;
    e.v = 0; e.id = 0; e.pr = 0; e.tag = tag;
    if (en) begin
      int best = 256;
      for (int r = 0; r < 64; r++) begin
        int s = ord[r];
        if (irq[s] && eff(s) < best) begin
          best = eff(s); e.id = s; e.v = 1;
        end
      end
      e.pr = e.v ? best : 0;
    end else begin
      for (int s = 63; s >= 0; s--) begin
        if (irq[s]) begin e.v = 1; e.id = s; e.pr = eff(s); end
      end
    end
    return e;
  endfunction

  task automatic wr(int idx, int val);
    wr_en_i = 1'b1; wr_idx_i = 7'(idx); wr_prio_i = 8'(val);
    if (idx < 64) mp[idx] = val;
    @(posedge clk_i); @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic apply(logic [63:0] irq, bit en, string tag);
    irq_i = irq; prio_en_i = en;
    q.push_back(model(irq, en, tag));
    @(posedge clk_i); @(negedge clk_i);
  endtask

  function automatic logic [63:0] bits(int a, int b = -1, int c = -1, int d = -1);
    logic [63:0] m = '0;
    m[a] = 1'b1;
    if (b >= 0) m[b] = 1'b1;
    if (c >= 0) m[c] = 1'b1;
    if (d >= 0) m[d] = 1'b1;
    return m;
  endfunction

  // Monitor: one expected item per driven cycle.
  initial begin
    forever begin
      @(posedge clk_i);
      if (q.size() > 0) begin
        exp_t e;
        @(negedge clk_i);
        e = q.pop_front();
        checks++;
        if (valid_o !== e.v || int'(id_o) != e.id || int'(prio_o) != e.pr) begin
          errors++;
          $display("FAIL %s: got v=%0d id=%0d prio=%0d exp v=%0d id=%0d prio=%0d",
                   e.tag, valid_o, id_o, prio_o, e.v, e.id, e.pr);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin mp[i] = 0; rnk[ord[i]] = i; end
    irq_i = bits(63, 11);
    repeat (3) @(negedge clk_i);
    checks++;
    if (valid_o !== 1'b0 || id_o !== 6'd0 || prio_o !== 8'd0) begin
      errors++;
      $display("FAIL R1 reset outputs: got v=%0d id=%0d prio=%0d exp 0 0 0", valid_o, id_o, prio_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);

    apply('0, 1, "R2 none pending");
    apply(bits(3, 7, 11), 1, "R4 ext default 128");
    apply(bits(3, 7), 1, "R7 tie 3 over 7");
    apply(bits(63, 11), 1, "R5 above ext gets 1");
    apply(bits(24, 11, 3), 1, "R6 rank of 24 above ext");
    apply(bits(0, 4, 16, 32), 1, "R6 low group ties");
    apply(bits(15, 0), 1, "R6 unlisted order");
    apply('0, 1, "R2 back to idle");

    wr(40, 5);
    apply(bits(40, 63, 11), 1, "R9 write visible next cycle");
    wr(63, 10);
    apply(bits(40, 63), 1, "R3 smaller wins");
    wr(20, 7); wr(50, 7);
    apply(bits(20, 50), 1, "R7 equal programmed tie");
    wr(5, 200);
    apply(bits(5, 11), 1, "R4 ext default beats 200");
    apply(bits(40, 5, 63), 0, "R8 lowest number wins");
    apply(bits(63, 50), 0, "R8 disabled reports eff prio");
    wr(64, 3); wr(127, 2);
    apply(bits(0), 1, "R10 out-of-range write ignored");
    wr(11, 2);
    apply(bits(11, 63, 40), 1, "R3 programmed ext");

    for (int it = 0; it < 300; it++) begin
      logic [63:0] r = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      if ($urandom_range(0, 2) == 0) begin
        int v = ($urandom_range(0, 1) == 0) ? 0 : $urandom_range(1, 255);
        wr($urandom_range(0, 80), v);
      end
      apply(r, $urandom_range(0, 3) != 0, "R3 random pattern");
    end

    repeat (3) @(negedge clk_i);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule